// File: doc/BRIEF.md
# Planar Routing Switch Box

This block sits at the crossing of a horizontal and a vertical routing channel in a programmable fabric. Each of its four sides (north, east, south, west) brings in `W` track wires and sends out `W` track wires. Stored configuration decides, for every outgoing wire, which incoming wire feeds it. Chaining boxes in this way lets a route continue past the single-block span of each wire segment.

Connectivity is domain-based. An outgoing wire on track `k` can take its value only from track `k` on one of the three other sides, or it can be left undriven, in which case it outputs 0. A side can never feed itself, because no select code names it. The routing path is purely combinational from the inputs and the stored selects.

The selects are loaded serially through a shift chain that is active while the load enable is high. The chain's last bit is brought out, so the chains of several boxes can be daisy-chained. All outputs are held at 0 while a load is in progress, so partly loaded settings never reach the fabric.

Top module: `sbox_planar`

## Requirements
- R1: A synchronous active-high reset clears every stored select to 00. After reset, every output is 0 and `cfg_dout` is 0.
- R2: On each rising clock edge with `cfg_en` high, `cfg_din` enters the top bit of the 8·W-bit configuration register and every other bit moves down one place. `cfg_dout` always shows bit 0, so the old bits leave in order from bit 0 upward.
- R3: While `cfg_en` is high, all 4·W outputs are 0, whatever the inputs are.
- R4: While `cfg_en` is low, clock edges leave the configuration unchanged and `cfg_din` has no effect.
- R5: The select for output side s (north=0, east=1, south=2, west=3) on track k occupies configuration bits [2(s·W+k)+1 : 2(s·W+k)].
- R6: An output whose select is 00 drives 0.
- R7: An output on side s with select code c in {1,2,3} copies the input on side (s+c) mod 4 at the same track. For example, north with code 1 takes east, with code 2 takes south, and with code 3 takes west.
- R8: An output on track k depends only on the inputs on track k. Changing any other track leaves it unchanged.
- R9: Outputs follow input changes within the same cycle, with no clock edge needed.
- R10: A single input may drive outputs on all three other sides at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset, clears all selects |
| cfg_en | input | 1 | Shift enable for the configuration chain; also holds the outputs quiet |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (bit 0 of the chain) |
| in_n | input | W | Incoming track wires, north side |
| in_e | input | W | Incoming track wires, east side |
| in_s | input | W | Incoming track wires, south side |
| in_w | input | W | Incoming track wires, west side |
| out_n | output | W | Outgoing track wires, north side |
| out_e | output | W | Outgoing track wires, east side |
| out_s | output | W | Outgoing track wires, south side |
| out_w | output | W | Outgoing track wires, west side |

## Verification
Three properties are checked on every clock. The outputs stay quiet during a load. The configuration is frozen when the chain is idle, and each shift captures the serial bit at the top. Any high output must also have a high input on the same track on one of the other sides. The exact source chosen by each code, the bit layout of the selects, and the serial order seen at `cfg_dout` can only be shown by the bench: it loads known settings, including fan-out and code sweeps, and compares every output with a model. Same-cycle input propagation and the insensitivity to other tracks are also covered only by bench scenarios.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int NSIDES = 4;
  localparam int SELW   = 2;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  // code 00 leaves the output undriven (0); codes 1..3 name side (s+code) mod 4
  localparam logic [SELW-1:0] SEL_NONE = 2'b00;

  function automatic int src_side(input int s, input int code);
    return (s + code) % NSIDES;
  endfunction
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [NBITS-1:0] cfg_q,
  output logic             dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      cfg_q <= {din, cfg_q[NBITS-1:1]};
    end
  end

  assign dout = cfg_q[0];

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cfg_q));

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (cfg_q[NBITS-1] == $past(din)));
endmodule

// File: rtl/sbox_track_mux.sv
module sbox_track_mux
  import sbox_pkg::*;
(
  input  logic [SELW-1:0] sel,
  input  logic [2:0]      cand,   // cand[j] is the same track on side (s+j+1) mod 4
  input  logic            quiet,
  output logic            y
);
  always_comb begin
    y = 1'b0;
    if (!quiet) begin
      unique case (sel)
        2'd1:    y = cand[0];
        2'd2:    y = cand[1];
        2'd3:    y = cand[2];
        default: y = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sbox_planar.sv
module sbox_planar
  import sbox_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic         cfg_dout,
  input  logic [W-1:0] in_n,
  input  logic [W-1:0] in_e,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_w,
  output logic [W-1:0] out_n,
  output logic [W-1:0] out_e,
  output logic [W-1:0] out_s,
  output logic [W-1:0] out_w
);
  localparam int NSEL  = NSIDES * W;
  localparam int NBITS = NSEL * SELW;

  logic [NBITS-1:0] cfg_q;
  logic [W-1:0]     in_side  [NSIDES];
  logic [W-1:0]     out_side [NSIDES];

  assign in_side[SIDE_N] = in_n;
  assign in_side[SIDE_E] = in_e;
  assign in_side[SIDE_S] = in_s;
  assign in_side[SIDE_W] = in_w;

  assign out_n = out_side[SIDE_N];
  assign out_e = out_side[SIDE_E];
  assign out_s = out_side[SIDE_S];
  assign out_w = out_side[SIDE_W];

  sbox_cfg_chain #(.NBITS(NBITS)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .cfg_q    (cfg_q),
    .dout     (cfg_dout)
  );

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    for (genvar k = 0; k < W; k++) begin : g_trk
      logic [2:0] cand;
      for (genvar j = 0; j < 3; j++) begin : g_cand
        assign cand[j] = in_side[(s + j + 1) % NSIDES][k];
      end

      sbox_track_mux u_mux (
        .sel   (cfg_q[SELW*(s*W+k) +: SELW]),
        .cand  (cand),
        .quiet (cfg_en),
        .y     (out_side[s][k])
      );

      // R8
      planar_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_side[s][k] |-> (in_side[(s+1)%NSIDES][k] | in_side[(s+2)%NSIDES][k]
                            | in_side[(s+3)%NSIDES][k]));
    end
  end

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> ((out_n | out_e | out_s | out_w) == '0));
endmodule

// File: tb/tb_sbox_planar.sv
module tb_sbox_planar;
  localparam int W  = 4;
  localparam int NB = 8 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_din = 1'b0, cfg_dout;
  logic [W-1:0] tin [4];
  logic [W-1:0] in_n, in_e, in_s, in_w, out_n, out_e, out_s, out_w;
  logic [NB-1:0] cur_cfg = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  assign in_n = tin[0];
  assign in_e = tin[1];
  assign in_s = tin[2];
  assign in_w = tin[3];

  always #4 clk = ~clk;

  sbox_planar #(.W(W)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w)
  );

  function automatic logic [W-1:0] exp_side(input int s, input logic [NB-1:0] cfg);
    logic [W-1:0] r = '0;
    for (int k = 0; k < W; k++) begin
      int code = int'(cfg[2*(s*W+k) +: 2]);
      if (code != 0) r[k] = tin[(s + code) % 4][k];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] act_side(input int s);
    case (s)
      0: return out_n;
      1: return out_e;
      2: return out_s;
      default: return out_w;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic [NB-1:0] cfg);
    for (int s = 0; s < 4; s++) check(req, 64'(act_side(s)), 64'(exp_side(s, cfg)));
  endtask

  task automatic check_zero(input string req);
    for (int s = 0; s < 4; s++) check(req, 64'(act_side(s)), 64'd0);
  endtask

  task automatic rand_inputs();
    for (int s = 0; s < 4; s++) tin[s] = W'($urandom);
  endtask

  // shifts bit 0 first; checks the old chain contents leaving at cfg_dout (R2)
  task automatic load(input logic [NB-1:0] nc);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      check("R2 serial out", 64'(cfg_dout), 64'(cur_cfg[i]));
      if (i == NB/2) begin
        for (int s = 0; s < 4; s++) tin[s] = '1;
        #1 check_zero("R3 quiet during load");
      end
      cfg_en = 1'b1;
      cfg_din = nc[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_din = 1'b0;
    cur_cfg = nc;
  endtask

  function automatic logic [NB-1:0] fill(input logic [1:0] code);
    logic [NB-1:0] r;
    for (int i = 0; i < NB/2; i++) r[2*i +: 2] = code;
    return r;
  endfunction

  initial begin
    logic [NB-1:0] c;
    logic [W-1:0] saved;
    void'($urandom(32'd1234));
    for (int s = 0; s < 4; s++) tin[s] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R1 reset dout", 64'(cfg_dout), 64'd0);
    check_zero("R1 reset outputs");

    // R6: all 00 with random inputs
    rand_inputs(); #1 check_zero("R6 select none");

    // R7: uniform code sweeps
    for (int code = 1; code < 4; code++) begin
      load(fill(2'(code)));
      for (int n = 0; n < 3; n++) begin rand_inputs(); #1 check_outs("R7 code sweep", cur_cfg); end
    end

    // R5: a single select set, others 00
    c = '0; c[2*(2*W+1) +: 2] = 2'd2;
    load(c);
    for (int s = 0; s < 4; s++) tin[s] = '1;
    #1;
    check("R5 field position", 64'(out_s), 64'(4'b0010));
    check("R5 other sides", 64'(out_n | out_e | out_w), 64'd0);

    // R10: east drives north(1), south(3), west(2)
    c = '0;
    for (int k = 0; k < W; k++) begin
      c[2*(0*W+k) +: 2] = 2'd1;
      c[2*(2*W+k) +: 2] = 2'd3;
      c[2*(3*W+k) +: 2] = 2'd2;
    end
    load(c);
    tin[0] = '0; tin[2] = '0; tin[3] = '0; tin[1] = 4'b1011;
    #1;
    check("R10 fanout north", 64'(out_n), 64'(4'b1011));
    check("R10 fanout south", 64'(out_s), 64'(4'b1011));
    check("R10 fanout west", 64'(out_w), 64'(4'b1011));

    // R4: cfg_din toggling with cfg_en low changes nothing
    rand_inputs();
    for (int n = 0; n < 10; n++) begin @(negedge clk); cfg_din = ~cfg_din; end
    #1 check_outs("R4 config held", cur_cfg);
    check("R4 dout held", 64'(cfg_dout), 64'(cur_cfg[0]));
    cfg_din = 1'b0;

    // random configurations; R8 and R9 checked against the model
    for (int t = 0; t < 20; t++) begin
      c = {$urandom, $urandom};
      load(c);
      for (int n = 0; n < 8; n++) begin
        rand_inputs();
        #1 check_outs("R7 random config", cur_cfg);
      end
      saved = out_n;
      for (int s = 0; s < 4; s++) tin[s][0] = ~tin[s][0];
      #1 check("R8 other tracks unchanged", 64'(out_n[W-1:1]), 64'(saved[W-1:1]));
      check_outs("R9 same-cycle follow", cur_cfg);
    end

    // R1: reset clears a loaded configuration
    load(fill(2'd2));
    for (int s = 0; s < 4; s++) tin[s] = '1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_zero("R1 reset clears config");
    check("R1 dout after reset", 64'(cfg_dout), 64'd0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule